// File: doc/BRIEF.md
# Byte-Wide Configuration Memory Loader

This block pulls a configuration image out of an external byte-wide memory and feeds it, one bit per clock, into an on-chip configuration shift chain. It drives a 20-bit address to the memory and reads back an 8-bit data bus. It captures one byte on a fixed eight-clock cadence and serializes each byte starting with bit 0. A byte count, sampled when a load is started, tells the block how many bytes belong to the current image.

The address pointer is kept between loads. Several images stored one after another can therefore be loaded in sequence. Each new start carries on from the location after the last byte of the previous image. Only the synchronous reset sets the pointer back to zero.

Top module: `cfg_byte_loader`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle after that edge: `mem_addr` = 0x00000, `ser_valid` = 0 and `done` = 0.
- R2: A load starts at the rising edge E0 where `start` = 1 and the block is idle or done. `mem_addr` presents the current pointer value from E0 onward. No bit is valid after E0 or after E1.
- R3: The byte on `mem_data` is captured at edge E2, and again at every eighth edge after that (E2 + 8k). During the eight cycles that follow each capture, `ser_bit` carries bit 0 first, then bits 1 through 7 in that order.
- R4: `ser_valid` is 1 throughout the 8·N cycles after E2 for an N-byte image. Consecutive bytes have no idle cycle between them.
- R5: `mem_addr` increments by exactly one at each capture edge and changes at no other time except reset.
- R6: At edge E2 + 8·N, `done` rises and `ser_valid` falls. While `done` stays set, `mem_addr` holds the address after the last byte and no bit is valid.
- R7: A `start` pulse seen while a load is in progress has no effect on the address sequence or the bitstream.
- R8: A new start does not clear the pointer. The first byte of a later load is read from the address that follows the last byte of the previous load.
- R9: A byte count of zero sets `done` at E2 with no valid bit and no address change.
- R10: `byte_total` is sampled only at E0. Changing it during a load does not change the number of bytes delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when idle or done |
| byte_total | input | 20 | Number of bytes in the image, sampled at start |
| mem_data | input | 8 | Byte returned by the external memory |
| mem_addr | output | 20 | Address driven to the external memory |
| ser_bit | output | 1 | Serialized configuration bit |
| ser_valid | output | 1 | High while `ser_bit` carries image data |
| done | output | 1 | Image complete; held until the next start or reset |

## Verification
The assertions check, on every cycle, the properties that hold locally. The address moves only by one and only while bits are flowing. `done` excludes valid bits and freezes the address. The valid strobe can only drop at completion. The reset state is checked as well. The bench scenarios are needed for the rest: the exact capture edge E2, the bit order and the byte-to-address pairing, the byte count, the ignored mid-load start and count change, the zero-length image, and pointer continuity across several back-to-back images.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int unsigned CFG_ADDR_W = 20;
    localparam int unsigned CFG_DATA_W = 8;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_PRIME = 2'd1,
        LD_RUN   = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_e;

    // Per-cycle control produced by the sequencer.
    typedef struct packed {
        logic take;    // capture a byte this edge
        logic finish;  // image complete this edge
    } ld_ctl_t;

    // Width of a counter that must hold values 0..n.
    function automatic int unsigned count_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width of an index that covers 0..n-1.
    function automatic int unsigned index_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
    import cfg_loader_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    assign addr = ptr_q;

endmodule

// File: rtl/cfg_byte_serializer.sv
module cfg_byte_serializer
    import cfg_loader_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              bit_out,
    output logic              bit_valid
);

    localparam int unsigned CNT_W = count_w(DATA_W);

    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            shreg_q <= din;
            left_q  <= CNT_W'(DATA_W);
        end else if (left_q != '0) begin
            shreg_q <= shreg_q >> 1;
            left_q  <= left_q - CNT_W'(1);
        end
    end

    assign bit_out   = shreg_q[0];
    assign bit_valid = (left_q != '0);

endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_loader_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_ADDR_W,
    parameter int unsigned DATA_W = CFG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] byte_total,
    output ld_ctl_t           ctl,
    output logic              done
);

    localparam int unsigned PH_W = index_w(DATA_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DATA_W - 1);

    ld_state_e         state_q;
    logic [PH_W-1:0]   phase_q;
    logic [ADDR_W-1:0] remain_q;
    logic              slot;

    always_comb begin
        slot       = (state_q == LD_RUN) && (phase_q == '0);
        ctl.take   = slot && (remain_q != '0);
        ctl.finish = slot && (remain_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LD_IDLE;
            phase_q  <= '0;
            remain_q <= '0;
        end else begin
            unique case (state_q)
                LD_IDLE, LD_DONE: begin
                    if (start) begin
                        state_q  <= LD_PRIME;
                        remain_q <= byte_total;
                    end
                end
                LD_PRIME: begin
                    state_q <= LD_RUN;
                    phase_q <= '0;
                end
                LD_RUN: begin
                    if (ctl.finish) begin
                        state_q <= LD_DONE;
                    end else begin
                        phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
                    end
                    if (ctl.take) begin
                        remain_q <= remain_q - ADDR_W'(1);
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign done = (state_q == LD_DONE);

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_ADDR_W,
    parameter int unsigned DATA_W = CFG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] byte_total,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              done
);

    ld_ctl_t ctl;

    cfg_load_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .byte_total(byte_total),
        .ctl       (ctl),
        .done      (done)
    );

    cfg_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk (clk),
        .rst (rst),
        .step(ctl.take),
        .addr(mem_addr)
    );

    cfg_byte_serializer #(
        .DATA_W(DATA_W)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.take),
        .din      (mem_data),
        .bit_out  (ser_bit),
        .bit_valid(ser_valid)
    );

endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ser_valid,
    input logic              done
);

    // R1: reset leaves the block idle at address zero
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (mem_addr == '0 && !ser_valid && !done));

    // R5: the address only ever moves forward by one
    a_r5_addr_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mem_addr != $past(mem_addr)) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R5: an address step coincides with a fresh byte entering the stream
    a_r5_step_on_fetch: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mem_addr != $past(mem_addr)) |-> ser_valid);

    // R6: no valid bits while done is set
    a_r6_done_silent: assert property (@(posedge clk) disable iff (rst)
        done |-> !ser_valid);

    // R6: the address is frozen while done holds
    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && done && $past(done)) |-> $stable(mem_addr));

    // R4: the stream only stops at completion, never with a gap
    a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(ser_valid)) |-> done);

endmodule

bind cfg_byte_loader cfg_byte_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .ser_valid(ser_valid),
    .done     (done)
);

// File: tb/cfg_byte_loader_tb.sv
module cfg_byte_loader_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] byte_total = '0;
    logic [7:0]  mem_data;
    logic [19:0] mem_addr;
    logic        ser_bit;
    logic        ser_valid;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic [19:0] exp_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory contents as a function of address.
    function automatic logic [7:0] memf(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], a[3:0]} ^ 8'h5A;
    endfunction

    assign mem_data = memf(mem_addr);

    cfg_byte_loader u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .byte_total(byte_total),
        .mem_data  (mem_data),
        .mem_addr  (mem_addr),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .done      (done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One complete load; optional start pulse and count change mid-run.
    task automatic run_load(input int n, input bit poke);
        logic [19:0] base;
        logic [7:0]  b;
        int j;
        check("R8 pointer kept before start", 32'(mem_addr), 32'(exp_ptr));
        base       = mem_addr;
        byte_total = 20'(n);
        start      = 1'b1;
        @(negedge clk);                       // after E0
        start = 1'b0;
        if (poke) byte_total = 20'(n + 3);    // R10: ignored after E0
        check("R2 addr at entry", 32'(mem_addr), 32'(base));
        check("R2 no valid after E0", 32'(ser_valid), 0);
        for (int c = 1; c <= 8 * n + 2; c++) begin
            @(negedge clk);
            if (poke && c == 5) start = 1'b1; // R7: pulse while busy
            if (poke && c == 6) start = 1'b0;
            if (c == 1) begin
                check("R2 no valid after E1", 32'(ser_valid), 0);
                check("R2 addr held before capture", 32'(mem_addr), 32'(base));
            end else if (c <= 8 * n + 1) begin
                j = c - 2;
                b = memf(base + 20'(j / 8));
                check(poke ? "R7 R10 R3 bit" : "R3 bit", 32'(ser_bit), 32'(b[j % 8]));
                check("R4 valid", 32'(ser_valid), 1);
                check("R5 addr", 32'(mem_addr), 32'(base + 20'(j / 8 + 1)));
                check("R6 not done", 32'(done), 0);
            end else begin
                check(n == 0 ? "R9 done" : "R6 done", 32'(done), 1);
                check("R6 valid low", 32'(ser_valid), 0);
                check("R6 final addr", 32'(mem_addr), 32'(base + 20'(n)));
            end
        end
        exp_ptr = base + 20'(n);
        repeat (4) @(negedge clk);
        check("R6 done holds", 32'(done), 1);
        check("R6 addr holds", 32'(mem_addr), 32'(exp_ptr));
        check("R6 no valid", 32'(ser_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset addr", 32'(mem_addr), 0);
        check("R1 reset valid", 32'(ser_valid), 0);
        check("R1 reset done", 32'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle valid", 32'(ser_valid), 0);

        run_load(3, 1'b0);
        run_load(0, 1'b0);   // R9
        run_load(5, 1'b1);   // R7, R10
        for (int k = 0; k < 8; k++) begin
            run_load(int'($urandom_range(1, 7)), 1'($urandom_range(0, 1)));
        end

        // R1: reset in the middle of a load
        byte_total = 20'd4;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (13) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-load reset addr", 32'(mem_addr), 0);
        check("R1 mid-load reset valid", 32'(ser_valid), 0);
        check("R1 mid-load reset done", 32'(done), 0);
        exp_ptr = '0;
        run_load(2, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule